// File: doc/BRIEF.md
# Two-Dimensional Strided Address Generator

This block walks one memory-mapped side of a DMA channel through a rectangular region. It takes a single transfer descriptor and emits a stream of bus-width beat addresses, one per handshake. The descriptor holds a start address, a row length in bytes minus one, a row count minus one, a row stride and a cyclic flag. Each row covers its bytes one bus word at a time. The next row begins one stride past the start of the row before it. A row count of zero gives a plain linear transfer.

In normal mode the generator returns to idle after the final beat of the final row and pulses a completion strobe. In cyclic mode it goes back to the first row and repeats until an abort arrives, and it never pulses completion. The beat output is a valid/ready stream. The consumer may stall it for any number of cycles, and while it is stalled the address and the row and transfer end flags stay frozen. Descriptors enter through a valid/ready handshake that is open only while the block is idle. The abort pin is a plain control input.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset, `beat_valid` and `done` are 0, `cur_addr` is 0, and `desc_ready` is 1 whenever `abort` is low.
- R2: `desc_ready` is 1 only in the idle state with `abort` low. An accepted descriptor makes `beat_valid` 1 on the next cycle. A descriptor offered while a transfer runs is ignored and does not alter the address sequence.
- R3: The low log2(BUS_BYTES) bits of the start address and of the stride are treated as zero. Each row has floor(`desc_x_len_m1` / BUS_BYTES) + 1 beats.
- R4: Within a row, each beat address is the previous one plus BUS_BYTES, modulo 2^ADDR_W.
- R5: There are `desc_y_len_m1` + 1 rows. The first beat of row r is at the aligned start plus r times the aligned stride. A row count field of 0 gives a single linear row.
- R6: `row_last` is 1 on the final beat of every row. `beat_last` is 1 only on the final beat of the final row.
- R7: In non-cyclic mode, `done` is 1 for exactly one cycle, in the cycle after the handshake of the final beat. In that same cycle `beat_valid` is 0 and `desc_ready` is 1.
- R8: In cyclic mode, the beat after the final beat of the final row is at the aligned start address again, and `done` never rises.
- R9: `abort` drops `beat_valid` on the next cycle without pulsing `done`. Once `abort` is low again, the block is idle with `desc_ready` at 1.
- R10: While `beat_valid` is 1 and `beat_ready` is 0 (and `abort` is low), `beat_valid`, `cur_addr`, `row_last` and `beat_last` keep their values on the next cycle. The sequence advances only on a handshake.
- R11: `cur_addr` is the address of the beat in progress. After completion it keeps the address of the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Stop the transfer and return to idle |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken (idle, no abort) |
| desc_start_addr | input | ADDR_W | Byte address of the first row |
| desc_x_len_m1 | input | LEN_W | Bytes per row minus one |
| desc_y_len_m1 | input | ROWS_W | Rows minus one |
| desc_stride | input | STRIDE_W | Byte distance between row starts |
| desc_cyclic | input | 1 | Repeat the region without end |
| beat_valid | output | 1 | A beat address is offered |
| beat_ready | input | 1 | Consumer takes the beat |
| cur_addr | output | ADDR_W | Address of the beat in progress |
| row_last | output | 1 | Beat is the final one of its row |
| beat_last | output | 1 | Beat is the final one of the transfer pass |
| done | output | 1 | One-cycle pulse when a non-cyclic transfer finishes |

## Verification
Embedded assertions check these behaviours on every cycle:
- the single-step increment inside a row and the stride step at a row boundary;
- alignment of every issued address;
- the freeze under back-pressure;
- the one-cycle done pulse and its absence in cyclic wrap;
- counter underflow;
- the one-cycle exit on abort.

The bench scenarios are what show the full address pattern of a whole region. They sweep start addresses, row lengths, row counts, strides (aligned, unaligned and wrapping past the top of the address space) and stall patterns. They also show that descriptors offered while busy are ignored, that a cyclic transfer comes back to the first row, and that a transfer started after an abort is clean.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic {
    SAG_IDLE = 1'b0,
    SAG_RUN  = 1'b1
  } sag_state_e;

endpackage

// File: rtl/sag_down_counter.sv
module sag_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign is_zero = (cnt_q == '0);

  // R5: the beat and row counts never step below zero
  assert_no_underflow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !is_zero);

endmodule

// File: rtl/sag_addr_unit.sv
module sag_addr_unit #(
  parameter int ADDR_W    = 32,
  parameter int STRIDE_W  = 24,
  parameter int BUS_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                restart,
  input  logic                step_row,
  input  logic                step_beat,
  output logic [ADDR_W-1:0]   addr
);

  localparam int LOG2_BUS = $clog2(BUS_BYTES);
  localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'(BUS_BYTES - 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_MASK;
  localparam logic [ADDR_W-1:0] BUS_INC    = ADDR_W'(BUS_BYTES);

  logic [ADDR_W-1:0] stride_in;
  logic [ADDR_W-1:0] stride_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] addr_q;

  generate
    if (STRIDE_W >= ADDR_W) begin : g_stride_trunc
      assign stride_in = stride[ADDR_W-1:0];
    end else begin : g_stride_ext
      assign stride_in = {{(ADDR_W-STRIDE_W){1'b0}}, stride};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stride_q <= '0;
      base_q   <= '0;
      row_q    <= '0;
      addr_q   <= '0;
    end else if (start) begin
      stride_q <= stride_in & ALIGN_MASK;
      base_q   <= start_addr & ALIGN_MASK;
      row_q    <= start_addr & ALIGN_MASK;
      addr_q   <= start_addr & ALIGN_MASK;
    end else if (restart) begin
      row_q    <= base_q;
      addr_q   <= base_q;
    end else if (step_row) begin
      row_q    <= row_q + stride_q;
      addr_q   <= row_q + stride_q;
    end else if (step_beat) begin
      addr_q   <= addr_q + BUS_INC;
    end
  end

  assign addr = addr_q;

  // R4: a beat step inside a row moves by exactly one bus word
  assert_beat_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (step_beat && !step_row && !restart && !start) |=> addr_q == $past(addr_q) + BUS_INC);

  // R5: a row step lands one stride past the previous row start
  assert_row_step_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (step_row && !restart && !start) |=> addr_q == $past(row_q) + $past(stride_q));

  // R8: a cyclic restart returns to the first row start
  assert_restart_base_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !start) |=> addr_q == base_q);

  generate
    if (LOG2_BUS > 0) begin : g_align_chk
      // R3: every issued address is bus-word aligned
      assert_aligned_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q & LOW_MASK) == '0);
    end
  endgenerate

endmodule

// File: rtl/sag_ctrl.sv
module sag_ctrl
  import sag_pkg::*;
#(
  parameter int LEN_W  = 24,
  parameter int ROWS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [LEN_W-1:0]  beats_m1_in,
  input  logic [ROWS_W-1:0] rows_m1_in,
  input  logic              cyclic_in,
  output logic              beat_valid,
  input  logic              beat_ready,
  input  logic              beat_zero,
  input  logic              row_zero,
  output logic              beat_load,
  output logic [LEN_W-1:0]  beat_load_val,
  output logic              beat_dec,
  output logic              row_load,
  output logic [ROWS_W-1:0] row_load_val,
  output logic              row_dec,
  output logic              addr_start,
  output logic              addr_restart,
  output logic              addr_row,
  output logic              addr_beat,
  output logic              row_last,
  output logic              beat_last,
  output logic              done
);

  sag_state_e        state_q;
  logic [LEN_W-1:0]  beats_m1_q;
  logic [ROWS_W-1:0] rows_m1_q;
  logic              cyclic_q;
  logic              done_q;

  logic accept;
  logic fire;
  logic row_end;
  logic pass_end;

  assign desc_ready = (state_q == SAG_IDLE) && !abort;
  assign accept     = desc_valid && desc_ready;
  assign beat_valid = (state_q == SAG_RUN);
  assign fire       = beat_valid && beat_ready;
  assign row_end    = fire && beat_zero;
  assign pass_end   = row_end && row_zero;

  assign row_last   = beat_valid && beat_zero;
  assign beat_last  = beat_valid && beat_zero && row_zero;

  assign beat_load     = accept || row_end;
  assign beat_load_val = accept ? beats_m1_in : beats_m1_q;
  assign beat_dec      = fire && !beat_zero;

  assign row_load      = accept || (pass_end && cyclic_q);
  assign row_load_val  = accept ? rows_m1_in : rows_m1_q;
  assign row_dec       = row_end && !row_zero;

  assign addr_start    = accept;
  assign addr_restart  = pass_end && cyclic_q;
  assign addr_row      = row_end && !row_zero;
  assign addr_beat     = fire && !beat_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SAG_IDLE;
      beats_m1_q <= '0;
      rows_m1_q  <= '0;
      cyclic_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= pass_end && !cyclic_q && !abort;
      if (abort) begin
        state_q <= SAG_IDLE;
      end else if (accept) begin
        state_q    <= SAG_RUN;
        beats_m1_q <= beats_m1_in;
        rows_m1_q  <= rows_m1_in;
        cyclic_q   <= cyclic_in;
      end else if (pass_end && !cyclic_q) begin
        state_q <= SAG_IDLE;
      end
    end
  end

  assign done = done_q;

  // R2: an accepted descriptor starts the beat stream on the next cycle
  assert_accept_runs_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> beat_valid);

  // R7: the final handshake of a normal transfer ends it with one done pulse
  assert_done_after_last_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !cyclic_q && !abort) |=> (done && !beat_valid));

  // R7: done never lasts two cycles
  assert_done_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a cyclic wrap keeps the stream alive and reports no completion
  assert_cyclic_no_done_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && cyclic_q && !abort) |=> (beat_valid && !done));

  // R9: abort empties the stream on the next cycle without completion
  assert_abort_idles_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!beat_valid && !done));

endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 24,
  parameter int ROWS_W    = 16,
  parameter int STRIDE_W  = 24,
  parameter int BUS_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                abort,
  input  logic                desc_valid,
  output logic                desc_ready,
  input  logic [ADDR_W-1:0]   desc_start_addr,
  input  logic [LEN_W-1:0]    desc_x_len_m1,
  input  logic [ROWS_W-1:0]   desc_y_len_m1,
  input  logic [STRIDE_W-1:0] desc_stride,
  input  logic                desc_cyclic,
  output logic                beat_valid,
  input  logic                beat_ready,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                row_last,
  output logic                beat_last,
  output logic                done
);

  localparam int LOG2_BUS = $clog2(BUS_BYTES);

  logic [LEN_W-1:0]  beats_m1_in;
  logic              beat_zero;
  logic              row_zero;
  logic              beat_load;
  logic [LEN_W-1:0]  beat_load_val;
  logic              beat_dec;
  logic              row_load;
  logic [ROWS_W-1:0] row_load_val;
  logic              row_dec;
  logic              addr_start;
  logic              addr_restart;
  logic              addr_row;
  logic              addr_beat;

  assign beats_m1_in = desc_x_len_m1 >> LOG2_BUS;

  sag_ctrl #(
    .LEN_W  (LEN_W),
    .ROWS_W (ROWS_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort         (abort),
    .desc_valid    (desc_valid),
    .desc_ready    (desc_ready),
    .beats_m1_in   (beats_m1_in),
    .rows_m1_in    (desc_y_len_m1),
    .cyclic_in     (desc_cyclic),
    .beat_valid    (beat_valid),
    .beat_ready    (beat_ready),
    .beat_zero     (beat_zero),
    .row_zero      (row_zero),
    .beat_load     (beat_load),
    .beat_load_val (beat_load_val),
    .beat_dec      (beat_dec),
    .row_load      (row_load),
    .row_load_val  (row_load_val),
    .row_dec       (row_dec),
    .addr_start    (addr_start),
    .addr_restart  (addr_restart),
    .addr_row      (addr_row),
    .addr_beat     (addr_beat),
    .row_last      (row_last),
    .beat_last     (beat_last),
    .done          (done)
  );

  sag_down_counter #(.W(LEN_W)) u_beat_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (beat_load),
    .load_val (beat_load_val),
    .dec      (beat_dec),
    .is_zero  (beat_zero)
  );

  sag_down_counter #(.W(ROWS_W)) u_row_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (row_load),
    .load_val (row_load_val),
    .dec      (row_dec),
    .is_zero  (row_zero)
  );

  sag_addr_unit #(
    .ADDR_W    (ADDR_W),
    .STRIDE_W  (STRIDE_W),
    .BUS_BYTES (BUS_BYTES)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (addr_start),
    .start_addr (desc_start_addr),
    .stride     (desc_stride),
    .restart    (addr_restart),
    .step_row   (addr_row),
    .step_beat  (addr_beat),
    .addr       (cur_addr)
  );

  // R10: a stalled beat holds its address and flags
  assert_stall_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready && !abort) |=>
      (beat_valid && $stable(cur_addr) && $stable(row_last) && $stable(beat_last)));

  // R6: the transfer end flag only appears on a row end
  assert_last_in_row_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> row_last);

endmodule

// File: tb/tb_stride_addr_gen.sv
module tb_stride_addr_gen;

  localparam int AW = 16;
  localparam int LW = 6;
  localparam int RW = 3;
  localparam int SW = 10;
  localparam int BB = 4;
  localparam int AMASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          abort = 1'b0;
  logic          desc_valid = 1'b0;
  logic          desc_ready;
  logic [AW-1:0] desc_start_addr = '0;
  logic [LW-1:0] desc_x_len_m1 = '0;
  logic [RW-1:0] desc_y_len_m1 = '0;
  logic [SW-1:0] desc_stride = '0;
  logic          desc_cyclic = 1'b0;
  logic          beat_valid;
  logic          beat_ready = 1'b0;
  logic [AW-1:0] cur_addr;
  logic          row_last;
  logic          beat_last;
  logic          done;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  stride_addr_gen #(
    .ADDR_W(AW), .LEN_W(LW), .ROWS_W(RW), .STRIDE_W(SW), .BUS_BYTES(BB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .abort(abort),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_start_addr(desc_start_addr), .desc_x_len_m1(desc_x_len_m1),
    .desc_y_len_m1(desc_y_len_m1), .desc_stride(desc_stride),
    .desc_cyclic(desc_cyclic),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .cur_addr(cur_addr), .row_last(row_last), .beat_last(beat_last),
    .done(done)
  );

  task automatic check_eq(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pick_ready(int mode, output logic rdy);
    if (mode == 0) begin
      rdy = 1'b1;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = lfsr[0] | lfsr[3];
    end
  endtask

  // Runs one descriptor. Called and returning at a falling edge.
  // abort_after < 0: run to completion (non-cyclic only)
  task automatic run_desc(int start, int xm1, int ym1, int stride, bit cyc,
                          int mode, bit noise, int abort_after);
    int beats, rows, total, sa, st, idx, issued, pass, r, b, expa, last_a;
    bit stalled;
    string tag;
    logic rdy;
    beats = xm1 / BB + 1;
    rows  = ym1 + 1;
    total = beats * rows;
    sa    = start & ~(BB - 1) & AMASK;
    st    = stride & ~(BB - 1);
    last_a = (sa + (rows - 1) * st + (beats - 1) * BB) & AMASK;
    desc_start_addr = AW'(start);
    desc_x_len_m1   = LW'(xm1);
    desc_y_len_m1   = RW'(ym1);
    desc_stride     = SW'(stride);
    desc_cyclic     = cyc;
    desc_valid      = 1'b1;
    #1;
    check_eq("R2", "desc_ready idle", int'(desc_ready), 1);
    @(negedge clk);
    desc_valid = noise;
    if (noise) begin
      desc_start_addr = AW'(start ^ 16'h5A50);
      desc_x_len_m1   = LW'(xm1 ^ 5);
      desc_y_len_m1   = RW'(ym1 ^ 2);
      desc_stride     = SW'(stride ^ 10'h150);
      desc_cyclic     = 1'b1;
    end
    idx = 0; issued = 0; pass = 0; stalled = 1'b0;
    forever begin
      check_eq("R2", "beat_valid running", int'(beat_valid), 1);
      check_eq("R2", "desc_ready busy", int'(desc_ready), 0);
      r = idx / beats;
      b = idx % beats;
      expa = (sa + r * st + b * BB) & AMASK;
      if (stalled)                tag = "R10";
      else if (pass > 0 && idx == 0) tag = "R8";
      else if (idx == 0)          tag = "R3";
      else if (b == 0)            tag = "R5";
      else                        tag = "R4";
      check_eq(tag, "cur_addr", int'(cur_addr), expa);
      check_eq("R6", "row_last", int'(row_last), int'(b == beats - 1));
      check_eq("R6", "beat_last", int'(beat_last), int'(b == beats - 1 && r == rows - 1));
      check_eq(cyc ? "R8" : "R7", "done while running", int'(done), 0);
      if (abort_after >= 0 && issued == abort_after) begin
        abort = 1'b1;
        beat_ready = 1'b0;
        desc_valid = 1'b0;
        #1;
        check_eq("R9", "desc_ready under abort", int'(desc_ready), 0);
        @(negedge clk);
        check_eq("R9", "beat_valid after abort", int'(beat_valid), 0);
        check_eq("R9", "done after abort", int'(done), 0);
        abort = 1'b0;
        #1;
        check_eq("R9", "desc_ready after abort", int'(desc_ready), 1);
        @(negedge clk);
        check_eq("R9", "done stays low", int'(done), 0);
        return;
      end
      pick_ready(mode, rdy);
      beat_ready = rdy;
      stalled = !rdy;
      if (rdy) begin
        issued++;
        idx++;
        if (idx == total) begin
          idx = 0;
          pass++;
          if (!cyc) begin
            desc_valid = 1'b0;
            @(negedge clk);
            beat_ready = 1'b0;
            check_eq("R7", "done pulse", int'(done), 1);
            check_eq("R7", "beat_valid after end", int'(beat_valid), 0);
            check_eq("R7", "desc_ready after end", int'(desc_ready), 1);
            check_eq("R11", "cur_addr holds final beat", int'(cur_addr), last_a);
            @(negedge clk);
            check_eq("R7", "done cleared", int'(done), 0);
            return;
          end
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int starts[3];
    int xlens[4];
    int strides[2];
    starts  = '{16'h0000, 16'h0123, 16'hFFF0};
    xlens   = '{0, 3, 5, 14};
    strides = '{16'h0010, 16'h03FF};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_eq("R1", "beat_valid reset", int'(beat_valid), 0);
    check_eq("R1", "done reset", int'(done), 0);
    check_eq("R1", "cur_addr reset", int'(cur_addr), 0);
    check_eq("R1", "desc_ready reset", int'(desc_ready), 1);
    @(negedge clk);

    // sweep of region shapes, alignments and stall patterns
    for (int si = 0; si < 3; si++)
      for (int xi = 0; xi < 4; xi++)
        for (int y = 0; y < 4; y++)
          for (int ti = 0; ti < 2; ti++)
            for (int m = 0; m < 2; m++)
              run_desc(starts[si], xlens[xi], y, strides[ti], 1'b0, m,
                       (si + xi + y) % 2 == 1, -1);

    // largest row count and length
    run_desc(16'h1000, 63, 7, 16'h0100, 1'b0, 1, 1'b0, -1);

    // cyclic: two full passes plus one beat, then abort (R8, R9)
    run_desc(16'h0204, 7, 2, 16'h0040, 1'b1, 1, 1'b1, 2 * 6 + 1);
    run_desc(16'hFFF8, 0, 0, 16'h0004, 1'b1, 0, 1'b0, 5);

    // abort in the middle of a normal transfer, then a clean transfer
    run_desc(16'h0040, 15, 2, 16'h0020, 1'b0, 1, 1'b0, 5);
    run_desc(16'h0800, 11, 1, 16'h0030, 1'b0, 0, 1'b0, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule